// File: doc/BRIEF.md
# Wired Interrupt Domain Controller

This block collects a set of wired interrupt lines, numbered 1 to N, and presents one interrupt request with the identity of the source that should be serviced first. Each line first passes through a two-flop synchroniser. It is then sensed according to a per-source mode: off, active-high level, active-low level, rising edge or falling edge. A source that is pending and enabled competes for the output on an 8-bit priority, where a smaller nonzero value is more urgent.

Software reaches every control and status bit through a simple 32-bit register bus. Writes are single-cycle strobes, and reads are combinational from the address. Pending and enable bits are exposed both as 32-bit bitmap words (one set view and one clear view) and as registers that take a source number. A claim register returns the winning source and clears its pending bit. A domain word holds the global output enable and a delivery-mode flag. A source that is switched off keeps its pending bit, its enable bit and its priority at zero and refuses writes to them.

Address map (byte offsets): domain word 0x000; enable-by-number set 0x004, clear 0x008; pending-by-number set 0x00C, clear 0x010; top-ID 0x014; claim 0x018; mode of source i at 0x100+4i; priority of source i at 0x200+4i; pending words set 0x300+4w, clear 0x320+4w; enable words set 0x340+4w, clear 0x360+4w. Bit b of word w stands for source 32w+b. Input bit k of `src_i` is source k+1.

Top module: `irq_domain_ctrl`

## Requirements
- R1: Mode encodings are 0 off, 1 level-high, 2 level-low, 3 rising edge and 4 falling edge. A write of any other value stores 0. The stored mode reads back in bits [2:0] of the source's mode register.
- R2: While a source is off, its pending bit, enable bit and priority read as zero and ignore writes. Switching a source off clears all three.
- R3: Bit 0 of bitmap word 0 always reads zero, since ID 0 names no source. Bits of sources that are off also stay zero after an all-ones write.
- R4: Writing a source number to 0x004 sets its enable bit. Writing it to 0x008 clears that bit.
- R5: A 1 in a write to a set-enable word sets that source's enable bit. A 1 in a write to a clear-enable word clears it, so an all-ones write disables the whole word.
- R6: The domain word keeps the global enable in bit 0 and the delivery mode in bit 1. Both read back exactly as written, and no other write changes them.
- R7: A read of a clear-pending word returns the rectified, synchronised input of each source (inverted for level-low and falling edge, zero when off). Writing that value to the set-pending word makes the asserted edge-mode sources pending.
- R8: After reset, every source is off, all enables are clear, the domain word is zero and `irq_o` is low.
- R9: In an edge mode, only the selected transition sets the pending bit. The bit stays set until the clear-pending number register, a clear-pending word or a claim removes it.
- R10: In a level mode, the pending bit follows the rectified input: it is high while the input is high for level-high, and while the input is low for level-low.
- R11: `irq_o` is high only when the global enable is set and a source is pending and enabled. `irq_id_o` then names the source with the smallest priority, the lowest ID winning ties. Otherwise `irq_id_o` is 0.
- R12: Writing 0 to a priority stores 1, and a source that is switched on from off starts at priority 1.
- R13: A read of 0x018 returns the winning ID in the low bits and its priority in bits [23:16], and clears that source's pending bit. It returns 0 when `irq_o` is low.
- R14: An input change reaches the pending bit, and through it `irq_o` and `irq_id_o`, on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSRC | Wired source lines, bit k is source k+1 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, qualifies the claim side effect |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Aggregated interrupt request |
| irq_id_o | output | ID_W | ID of the winning source, 0 when idle |

## Verification
Register writes take effect on the rising edge during the strobe, so readback and output checks are made at the next falling edge. Read data is sampled shortly after the address is applied, and a claim's clearing of the pending bit is observed one edge later. An input change is expected on the outputs on exactly the third rising edge: the bench checks after two edges that nothing has moved yet, and checks again after the third. A mode change on a level source updates its pending bit one edge after the write, and the checks wait that single cycle.

// File: rtl/irq_dom_pkg.sv
package irq_dom_pkg;

  typedef enum logic [2:0] {
    SM_OFF  = 3'd0,
    SM_HIGH = 3'd1,
    SM_LOW  = 3'd2,
    SM_RISE = 3'd3,
    SM_FALL = 3'd4
  } smode_e;

  // byte offsets of the register windows
  localparam int unsigned A_DOMCFG   = 32'h000;
  localparam int unsigned A_SETEN_N  = 32'h004;
  localparam int unsigned A_CLREN_N  = 32'h008;
  localparam int unsigned A_SETPD_N  = 32'h00C;
  localparam int unsigned A_CLRPD_N  = 32'h010;
  localparam int unsigned A_TOPID    = 32'h014;
  localparam int unsigned A_CLAIM    = 32'h018;
  localparam int unsigned A_MODE     = 32'h100;
  localparam int unsigned A_PRIO     = 32'h200;
  localparam int unsigned A_SETPD_W  = 32'h300;
  localparam int unsigned A_CLRPD_W  = 32'h320;
  localparam int unsigned A_SETEN_W  = 32'h340;
  localparam int unsigned A_CLREN_W  = 32'h360;

  function automatic smode_e legal_mode(input logic [2:0] v);
    case (v)
      3'd1:    return SM_HIGH;
      3'd2:    return SM_LOW;
      3'd3:    return SM_RISE;
      3'd4:    return SM_FALL;
      default: return SM_OFF;
    endcase
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_dom_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_i,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_wd,
  input  logic              prio_we,
  input  logic [PRIO_W-1:0] prio_wd,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              pd_set,
  input  logic              pd_clr,
  output logic [2:0]        mode_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              en_o,
  output logic              pd_o,
  output logic              rect_o
);

  logic              s1_q, s2_q, s3_q;
  smode_e            mode_q, mode_n;
  logic [PRIO_W-1:0] prio_q, prio_n;
  logic              en_q, en_n, pd_q, pd_n;
  logic              active, invert, is_level, edge_hit, rect;
  logic              prio_ld, en_ld;

  always_comb begin
    active   = (mode_q != SM_OFF);
    invert   = (mode_q == SM_LOW) || (mode_q == SM_FALL);
    is_level = (mode_q == SM_HIGH) || (mode_q == SM_LOW);
    rect     = active && (s2_q ^ invert);
    edge_hit = ((mode_q == SM_RISE) && s2_q && !s3_q) ||
               ((mode_q == SM_FALL) && !s2_q && s3_q);

    mode_n = cfg_we ? legal_mode(cfg_wd) : mode_q;
    en_n   = en_q;
    prio_n = prio_q;
    pd_n   = pd_q;

    if (active) begin
      if (en_set)  en_n = 1'b1;
      if (en_clr)  en_n = 1'b0;
      if (prio_we) prio_n = (prio_wd == '0) ? PRIO_W'(1) : prio_wd;
      if (is_level) pd_n = rect;
      else          pd_n = (pd_q || edge_hit || pd_set) && !pd_clr;
    end

    if (mode_n == SM_OFF) begin
      en_n   = 1'b0;
      prio_n = '0;
      pd_n   = 1'b0;
    end else if (!active) begin
      prio_n = PRIO_W'(1);
    end

    prio_ld = prio_we || cfg_we;
    en_ld   = en_set || en_clr || cfg_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      mode_q <= SM_OFF;
      prio_q <= '0;
      en_q   <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      s1_q <= src_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      pd_q <= pd_n;
      if (cfg_we)  mode_q <= mode_n;
      if (prio_ld) prio_q <= prio_n;
      if (en_ld)   en_q   <= en_n;
    end
  end

  assign mode_o = mode_q;
  assign prio_o = prio_q;
  assign en_o   = en_q;
  assign pd_o   = pd_q;
  assign rect_o = rect;

  // R2
  inactive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SM_OFF) |-> (!pd_q && !en_q && (prio_q == '0)));

  // R12
  prio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != SM_OFF) |-> (prio_q != '0));

  // R9
  edge_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && !pd_clr && !cfg_we) |=> pd_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC   = 40,
  parameter int PRIO_W = 8,
  parameter int ID_W   = 6
) (
  input  logic [NSRC-1:0]   cand,
  input  logic [PRIO_W-1:0] prio [NSRC],
  output logic              found,
  output logic [ID_W-1:0]   best_id,
  output logic [PRIO_W-1:0] best_prio
);

  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (prio[i] != '0) && (!found || (prio[i] < best_prio))) begin
        found     = 1'b1;
        best_id   = ID_W'(i + 1);
        best_prio = prio[i];
      end
    end
  end

endmodule

// File: rtl/irq_domain_ctrl.sv
module irq_domain_ctrl
  import irq_dom_pkg::*;
#(
  parameter int NSRC   = 40,
  parameter int PRIO_W = 8,
  parameter int ADDR_W = 12,
  parameter int ID_W   = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o
);

  localparam int NWORD = (NSRC + 32) / 32;
  localparam int MAP_W = NWORD * 32;

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_s_n <= rs1_q;
    end
  end

  // domain word
  logic dom_ie_q, dom_dm_q, wr_dom;
  assign wr_dom = bus_wr && (bus_addr == ADDR_W'(A_DOMCFG));

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      dom_ie_q <= 1'b0;
      dom_dm_q <= 1'b0;
    end else if (wr_dom) begin
      dom_ie_q <= bus_wdata[0];
      dom_dm_q <= bus_wdata[1];
    end
  end

  // per-source strobes
  logic [NSRC-1:0]   cfg_we, prio_we, en_set, en_clr, pd_set, pd_clr;
  logic [NSRC-1:0]   en_a, pd_a, rect_a;
  logic [2:0]        mode_a [NSRC];
  logic [PRIO_W-1:0] prio_a [NSRC];
  logic              found;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic              claim_hit;

  assign claim_hit = bus_rd && (bus_addr == ADDR_W'(A_CLAIM)) && irq_o;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      cfg_we[i]  = bus_wr && (bus_addr == ADDR_W'(A_MODE + 4 * (i + 1)));
      prio_we[i] = bus_wr && (bus_addr == ADDR_W'(A_PRIO + 4 * (i + 1)));
      en_set[i]  = bus_wr &&
        (((bus_addr == ADDR_W'(A_SETEN_W + 4 * ((i + 1) / 32))) && bus_wdata[(i + 1) % 32]) ||
         ((bus_addr == ADDR_W'(A_SETEN_N)) && (bus_wdata == 32'(i + 1))));
      en_clr[i]  = bus_wr &&
        (((bus_addr == ADDR_W'(A_CLREN_W + 4 * ((i + 1) / 32))) && bus_wdata[(i + 1) % 32]) ||
         ((bus_addr == ADDR_W'(A_CLREN_N)) && (bus_wdata == 32'(i + 1))));
      pd_set[i]  = bus_wr &&
        (((bus_addr == ADDR_W'(A_SETPD_W + 4 * ((i + 1) / 32))) && bus_wdata[(i + 1) % 32]) ||
         ((bus_addr == ADDR_W'(A_SETPD_N)) && (bus_wdata == 32'(i + 1))));
      pd_clr[i]  = (bus_wr &&
        (((bus_addr == ADDR_W'(A_CLRPD_W + 4 * ((i + 1) / 32))) && bus_wdata[(i + 1) % 32]) ||
         ((bus_addr == ADDR_W'(A_CLRPD_N)) && (bus_wdata == 32'(i + 1))))) ||
        (claim_hit && (irq_id_o == ID_W'(i + 1)));
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irq_src_cell #(.PRIO_W(PRIO_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .src_i   (src_i[g]),
      .cfg_we  (cfg_we[g]),
      .cfg_wd  (bus_wdata[2:0]),
      .prio_we (prio_we[g]),
      .prio_wd (bus_wdata[PRIO_W-1:0]),
      .en_set  (en_set[g]),
      .en_clr  (en_clr[g]),
      .pd_set  (pd_set[g]),
      .pd_clr  (pd_clr[g]),
      .mode_o  (mode_a[g]),
      .prio_o  (prio_a[g]),
      .en_o    (en_a[g]),
      .pd_o    (pd_a[g]),
      .rect_o  (rect_a[g])
    );
  end

  irq_prio_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
    .cand      (pd_a & en_a),
    .prio      (prio_a),
    .found     (found),
    .best_id   (best_id),
    .best_prio (best_prio)
  );

  assign irq_o    = found && dom_ie_q;
  assign irq_id_o = irq_o ? best_id : '0;

  // bitmaps indexed by source ID, bit 0 unused
  logic [MAP_W-1:0] pd_map, en_map, rect_map;
  always_comb begin
    pd_map   = '0;
    en_map   = '0;
    rect_map = '0;
    pd_map[NSRC:1]   = pd_a;
    en_map[NSRC:1]   = en_a;
    rect_map[NSRC:1] = rect_a;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_DOMCFG)) bus_rdata = {30'd0, dom_dm_q, dom_ie_q};
    if (((bus_addr == ADDR_W'(A_TOPID)) || (bus_addr == ADDR_W'(A_CLAIM))) && irq_o) begin
      bus_rdata[ID_W-1:0]     = irq_id_o;
      bus_rdata[16 +: PRIO_W] = best_prio;
    end
    for (int i = 0; i < NSRC; i++) begin
      if (bus_addr == ADDR_W'(A_MODE + 4 * (i + 1))) bus_rdata = {29'd0, mode_a[i]};
      if (bus_addr == ADDR_W'(A_PRIO + 4 * (i + 1))) bus_rdata = 32'(prio_a[i]);
    end
    for (int w = 0; w < NWORD; w++) begin
      if (bus_addr == ADDR_W'(A_SETPD_W + 4 * w)) bus_rdata = pd_map[32 * w +: 32];
      if (bus_addr == ADDR_W'(A_CLRPD_W + 4 * w)) bus_rdata = rect_map[32 * w +: 32];
      if (bus_addr == ADDR_W'(A_SETEN_W + 4 * w)) bus_rdata = en_map[32 * w +: 32];
    end
  end

  // R11
  id_range_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_o |-> ((irq_id_o != '0) && (irq_id_o <= ID_W'(NSRC))));

  // R6
  domcfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wr_dom |=> $stable({dom_ie_q, dom_dm_q}));

endmodule

// File: tb/irq_domain_ctrl_tb.sv
module irq_domain_ctrl_tb;

  localparam int NSRC   = 40;
  localparam int PRIO_W = 8;
  localparam int ADDR_W = 12;
  localparam int ID_W   = 6;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_SRC = 3'd2, OP_WAIT = 3'd3, OP_IRQ = 3'd4;

  logic              clk, rst_n;
  logic [NSRC-1:0]   src;
  logic              bus_wr, bus_rd;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              irq_o;
  logic [ID_W-1:0]   irq_id_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_domain_ctrl #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .irq_id_o(irq_id_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [50:0] v(input logic [2:0] op, input logic [3:0] rq,
                                    input logic [11:0] a, input logic [31:0] d);
    return {op, rq, a, d};
  endfunction

  localparam int NV = 64;
  localparam logic [50:0] VEC [NV] = '{
    v(OP_WR,  0, 12'h004, 32'd5),
    v(OP_RD,  2, 12'h340, 32'h0),          // R2 enable of an off source
    v(OP_WR,  0, 12'h214, 32'd9),
    v(OP_RD,  2, 12'h214, 32'h0),          // R2 priority of an off source
    v(OP_WR,  0, 12'h114, 32'd6),
    v(OP_RD,  1, 12'h114, 32'h0),          // R1 illegal mode stores off
    v(OP_WR,  0, 12'h114, 32'd3),
    v(OP_RD,  1, 12'h114, 32'd3),          // R1 rising edge
    v(OP_RD, 12, 12'h214, 32'd1),          // R12 switched on at 1
    v(OP_WR,  0, 12'h214, 32'd0),
    v(OP_RD, 12, 12'h214, 32'd1),          // R12 zero stores 1
    v(OP_WR,  0, 12'h214, 32'd4),
    v(OP_RD, 12, 12'h214, 32'd4),          // R12
    v(OP_WR,  0, 12'h004, 32'd5),
    v(OP_RD,  4, 12'h340, 32'h20),         // R4 set by number
    v(OP_WR,  0, 12'h000, 32'd3),
    v(OP_RD,  6, 12'h000, 32'd3),          // R6 readback
    v(OP_SRC, 0, 12'd5,   32'd1),
    v(OP_WAIT,0, 12'h0,   32'd2),
    v(OP_IRQ,14, 12'h0,   32'h000),        // R14 not yet after two edges
    v(OP_WAIT,0, 12'h0,   32'd1),
    v(OP_IRQ, 9, 12'h0,   32'h105),        // R9 rising edge pends
    v(OP_SRC, 0, 12'd5,   32'd0),
    v(OP_WR,  0, 12'h010, 32'd5),
    v(OP_IRQ, 9, 12'h0,   32'h000),        // R9 cleared by number
    v(OP_WR,  0, 12'h184, 32'd1),
    v(OP_WR,  0, 12'h284, 32'd2),
    v(OP_WR,  0, 12'h344, 32'h2),
    v(OP_SRC, 0, 12'd33,  32'd1),
    v(OP_WAIT,0, 12'h0,   32'd3),
    v(OP_IRQ,10, 12'h0,   32'h121),        // R10 level-high
    v(OP_RD,  7, 12'h324, 32'h2),          // R7 rectified input
    v(OP_SRC, 0, 12'd5,   32'd1),
    v(OP_WAIT,0, 12'h0,   32'd3),
    v(OP_IRQ,11, 12'h0,   32'h121),        // R11 smaller priority wins
    v(OP_WR,  0, 12'h214, 32'd2),
    v(OP_IRQ,11, 12'h0,   32'h105),        // R11 tie goes to lower ID
    v(OP_RD, 13, 12'h018, 32'h00020005),   // R13 claim value
    v(OP_IRQ,13, 12'h0,   32'h121),        // R13 claim cleared source 5
    v(OP_WR,  0, 12'h184, 32'd2),
    v(OP_WAIT,0, 12'h0,   32'd1),
    v(OP_IRQ,10, 12'h0,   32'h000),        // R10 level-low, input high
    v(OP_SRC, 0, 12'd33,  32'd0),
    v(OP_WAIT,0, 12'h0,   32'd3),
    v(OP_IRQ,10, 12'h0,   32'h121),        // R10 level-low, input low
    v(OP_WR,  0, 12'h364, 32'hFFFFFFFF),
    v(OP_IRQ, 5, 12'h0,   32'h000),        // R5 word clear
    v(OP_WR,  0, 12'h004, 32'd33),
    v(OP_IRQ, 4, 12'h0,   32'h121),        // R4
    v(OP_WR,  0, 12'h000, 32'd2),
    v(OP_IRQ,11, 12'h0,   32'h000),        // R11 global enable off
    v(OP_RD,  6, 12'h000, 32'd2),          // R6
    v(OP_WR,  0, 12'h11C, 32'd4),
    v(OP_WR,  0, 12'h21C, 32'd3),
    v(OP_WR,  0, 12'h004, 32'd7),
    v(OP_WR,  0, 12'h000, 32'd1),
    v(OP_WR,  0, 12'h008, 32'd33),
    v(OP_IRQ, 4, 12'h0,   32'h000),        // R4 clear by number
    v(OP_SRC, 0, 12'd7,   32'd1),
    v(OP_WAIT,0, 12'h0,   32'd3),
    v(OP_IRQ, 9, 12'h0,   32'h000),        // R9 rise ignored in falling mode
    v(OP_SRC, 0, 12'd7,   32'd0),
    v(OP_WAIT,0, 12'h0,   32'd3),
    v(OP_IRQ, 9, 12'h0,   32'h107)         // R9 falling edge pends
  };

  task automatic check(input int rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got 0x%08h expected 0x%08h", rq, what, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] irq_word();
    return {23'd0, irq_o, 2'd0, irq_id_o};
  endfunction

  task automatic reset_and_check();
    logic [31:0] d;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8 reset state
    bus_read(12'h000, d); check(8, "domain word after reset", d, 32'h0);
    bus_read(12'h114, d); check(8, "mode after reset", d, 32'h0);
    bus_read(12'h340, d); check(8, "enables after reset", d, 32'h0);
    check(8, "irq after reset", irq_word(), 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    reset_and_check();

    for (int k = 0; k < NV; k++) begin
      automatic logic [50:0] e = VEC[k];
      automatic logic [2:0]  op = e[50:48];
      automatic int          rq = int'(e[47:44]);
      automatic logic [11:0] a  = e[43:32];
      automatic logic [31:0] dd = e[31:0];
      case (op)
        OP_WR:   bus_write(a, dd);
        OP_RD:   begin bus_read(a, d); check(rq, $sformatf("vec %0d read 0x%03h", k, a), d, dd); end
        OP_SRC:  src[int'(a) - 1] = dd[0];
        OP_WAIT: repeat (int'(dd)) @(negedge clk);
        default: check(rq, $sformatf("vec %0d irq", k), irq_word(), dd);
      endcase
    end

    // R2 switching off clears state
    bus_write(12'h11C, 32'd0);
    check(2, "irq after source 7 off", irq_word(), 32'h0);
    bus_read(12'h21C, d); check(2, "priority of switched-off source", d, 32'h0);
    bus_read(12'h340, d); check(2, "enable word after switch-off", d, 32'h20);
    // R7 resample: read rectified inputs, write them to set-pending
    bus_read(12'h320, d); check(7, "rectified word 0", d, 32'h20);
    bus_write(12'h300, d);
    check(7, "irq after pending resample", irq_word(), 32'h105);
    // R3 bit 0 and off sources stay zero
    bus_write(12'h340, 32'hFFFFFFFF);
    bus_read(12'h340, d); check(3, "enable word all ones", d, 32'h20);
    bus_write(12'h300, 32'hFFFFFFFF);
    bus_read(12'h300, d); check(3, "pending word all ones", d, 32'h20);

    reset_and_check();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule